// File: doc/BRIEF.md
# READY-Trap Pseudo-DMA Handshake

This block lets a processor act as the DMA engine of a floppy disk controller. It does this by stalling the processor on its READY input. Software first sets an arm bit. It then loops once per sector byte. In each pass it first touches a halt address, which pulls READY low until the controller raises its data request. It then reads or writes a data address. That second access drives the active-low acknowledge, so the controller puts a byte on the bus, or takes one from it, and drops its request. Ordinary load and store instructions therefore carry every byte.

Two escapes keep the processor from hanging. An expired timeout forces READY high. Clearing the arm bit releases any stall. A separate control bit can pulse the acknowledge before a transfer starts. This clears a request left pending by an earlier aborted access. The data request and the timeout state come from outside the clock domain, so they pass through a synchronizer whose depth is a parameter.

Top module: `dma_ready_trap`

## Requirements
- R1: During and straight after reset, with all inputs low, `ready_o` is 1 and `ack_n_o` is 1.
- R2: While `arm_i` is 0, `ready_o` stays 1 whatever the halt strobe does.
- R3: With `arm_i` at 1, the synchronized request at 0 and no timeout, a halt strobe drives `ready_o` to 0 in the same cycle. `ready_o` stays 0 after the strobe ends, for as long as that condition lasts.
- R4: A stall ends when the request is seen at 1. With `SYNC_STAGES`=N, `ready_o` is still 0 N-1 clock edges after `drq_i` rises, and is 1 after N edges.
- R5: `ack_n_o` is 0 in the same cycle as the data strobe `data_acc_i`. It is 1 whenever neither the data strobe nor the clear bit is 1.
- R6: Once a stall has ended, `ready_o` stays 1 until the next halt strobe, even after the request drops back to 0.
- R7: An expired timeout (`tmo_exp_i`=1, seen after N edges) forces `ready_o` to 1 and drops the stall. `ready_o` stays 1 after the timeout input returns to 0.
- R8: `ack_n_o` is 0 for every cycle that `clr_ack_i` is 1.
- R9: A halt strobe while the synchronized request is already 1 does not stall. Once the request has been cleared through the acknowledge, the next halt strobe stalls again.
- R10: Clearing `arm_i` during a stall drives `ready_o` to 1 in the same cycle. Setting `arm_i` again without a halt strobe leaves `ready_o` at 1.
- R11: A 256-pass halt-then-data loop, with the request raised after varying delays, stalls on every halt strobe and moves all 256 bytes in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Trap enable bit |
| halt_acc_i | input | 1 | Decoded strobe for an access to the halt address |
| data_acc_i | input | 1 | Decoded strobe for an access to the data address |
| clr_ack_i | input | 1 | Control bit that pulses the acknowledge to clear a stale request |
| drq_i | input | 1 | Controller data request (asynchronous) |
| tmo_exp_i | input | 1 | Timeout monostable has expired (asynchronous) |
| ready_o | output | 1 | Processor READY (0 means wait) |
| ack_n_o | output | 1 | Active-low acknowledge to the controller |

## Verification
The handshake is tried with four input patterns:
- A request that arrives after the halt strobe, which shows that the stall holds and is then released.
- A request that never arrives, which shows that the timeout escape works on its own.
- A request that is already pending at the halt strobe, which shows the missed-byte hazard and how the clear bit cures it.
- A 256-pass loop with request delays from zero to several cycles, which shows that the link is set again on each pass and never carried over.

Disarming during a stall and the exact synchronizer latency are checked cycle by cycle. Together these cases separate a stall that lingers from one that drops too early.

// File: rtl/dmatrap_pkg.sv
package dmatrap_pkg;
   localparam int unsigned MAX_SYNC_STAGES = 4;

   typedef enum logic {
      TRAP_OPEN = 1'b0,
      TRAP_HOLD = 1'b1
   } trap_state_e;

   localparam int unsigned SYNC_SIG_DRQ = 0;
   localparam int unsigned SYNC_SIG_TMO = 1;
   localparam int unsigned SYNC_WIDTH   = 2;
endpackage

// File: rtl/dmatrap_sync.sv
module dmatrap_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (WIDTH == 0) begin : g_bad_width
      $error("dmatrap_sync: WIDTH must be non-zero");
   end

   if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
         end else begin
            stage_q[0] <= async_i;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
         end
      end

      assign sync_o = stage_q[STAGES-1];
   end
endmodule

// File: rtl/dmatrap_stall.sv
module dmatrap_stall
   import dmatrap_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic halt_acc_i,
   input  logic drq_s_i,
   input  logic tmo_s_i,
   output logic ready_o
);
   trap_state_e state_q;
   logic        hold_now;

   // The link from request to READY exists only between a halt access and
   // the next request, timeout or disarm.
   always_comb begin
      hold_now = arm_i && !tmo_s_i && !drq_s_i &&
                 (halt_acc_i || (state_q == TRAP_HOLD));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= TRAP_OPEN;
      else        state_q <= hold_now ? TRAP_HOLD : TRAP_OPEN;
   end

   assign ready_o = !hold_now;

   // R3: a stall persists until request, timeout or disarm
   a_r3_stall_persists: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_o && arm_i) |=> (!ready_o || drq_s_i || tmo_s_i || !arm_i));

   // R6: once open, READY stays high until a new halt access
   a_r6_no_relink: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !halt_acc_i) |=> (ready_o || halt_acc_i));

   // R7: timeout drops the stall state
   a_r7_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_s_i |=> (state_q == TRAP_OPEN));

   // R4: a rising request releases the processor
   a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drq_s_i) |-> ready_o);
endmodule

// File: rtl/dmatrap_ack.sv
module dmatrap_ack (
   input  logic clk,
   input  logic rst_n,
   input  logic data_acc_i,
   input  logic clr_ack_i,
   output logic ack_n_o
);
   always_comb ack_n_o = !(data_acc_i || clr_ack_i);

   // R5: the data strobe asserts the acknowledge
   a_r5_ack_on_data: assert property (@(posedge clk) disable iff (!rst_n)
      data_acc_i |-> !ack_n_o);

   // R8: the clear bit asserts the acknowledge
   a_r8_ack_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ack_i |-> !ack_n_o);

   // R5: idle acknowledge is high
   a_r5_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_acc_i && !clr_ack_i) |-> ack_n_o);
endmodule

// File: rtl/dma_ready_trap.sv
module dma_ready_trap
   import dmatrap_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic halt_acc_i,
   input  logic data_acc_i,
   input  logic clr_ack_i,
   input  logic drq_i,
   input  logic tmo_exp_i,
   output logic ready_o,
   output logic ack_n_o
);
   if (SYNC_STAGES > MAX_SYNC_STAGES) begin : g_bad_sync
      $error("dma_ready_trap: SYNC_STAGES exceeds MAX_SYNC_STAGES");
   end

   logic [SYNC_WIDTH-1:0] async_bus;
   logic [SYNC_WIDTH-1:0] sync_bus;

   always_comb begin
      async_bus               = '0;
      async_bus[SYNC_SIG_DRQ] = drq_i;
      async_bus[SYNC_SIG_TMO] = tmo_exp_i;
   end

   dmatrap_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (SYNC_WIDTH)
   ) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (async_bus),
      .sync_o  (sync_bus)
   );

   dmatrap_stall stall_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (arm_i),
      .halt_acc_i (halt_acc_i),
      .drq_s_i    (sync_bus[SYNC_SIG_DRQ]),
      .tmo_s_i    (sync_bus[SYNC_SIG_TMO]),
      .ready_o    (ready_o)
   );

   dmatrap_ack ack_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .data_acc_i (data_acc_i),
      .clr_ack_i  (clr_ack_i),
      .ack_n_o    (ack_n_o)
   );

   // R2: a disarmed trap never holds the processor
   a_r2_disarmed_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_i |-> ready_o);

   // R10: disarm during a stall releases at once and stays open
   a_r10_disarm_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm_i && !halt_acc_i) |=> (ready_o || halt_acc_i));
endmodule

// File: tb/dma_ready_trap_tb_top.sv
module dma_ready_trap_tb_top;
   localparam int unsigned SYNC = 2;
   localparam int unsigned NBYTES = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0, halt = 1'b0, data = 1'b0, clr = 1'b0;
   logic drq = 1'b0, tmo = 1'b0;
   logic ready, ack_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] ctl_byte;
   logic [7:0] mem [NBYTES];

   always #10 clk = ~clk;

   dma_ready_trap #(.SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .halt_acc_i(halt),
      .data_acc_i(data), .clr_ack_i(clr), .drq_i(drq), .tmo_exp_i(tmo),
      .ready_o(ready), .ack_n_o(ack_n)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pattern(input int i);
      return 8'((i * 37 + 11) ^ (i >> 3));
   endfunction

   task automatic t_reset();
      #2;
      chk("R1 ready in reset", 32'(ready), 1);
      chk("R1 ack_n in reset", 32'(ack_n), 1);
      tick();
      rst_n = 1'b1;
      tick();
      #2;
      chk("R1 ready after reset", 32'(ready), 1);
      chk("R1 ack_n after reset", 32'(ack_n), 1);
   endtask

   task automatic t_disarmed();
      arm = 1'b0;
      halt = 1'b1;
      #2;
      chk("R2 ready during halt while disarmed", 32'(ready), 1);
      tick();
      halt = 1'b0;
      tick();
      #2;
      chk("R2 ready after halt while disarmed", 32'(ready), 1);
   endtask

   task automatic t_stall_release();
      arm = 1'b1;
      tick();
      halt = 1'b1;
      #2;
      chk("R3 ready low in halt cycle", 32'(ready), 0);
      tick();
      halt = 1'b0;
      #2;
      chk("R3 ready low after strobe", 32'(ready), 0);
      repeat (5) tick();
      chk("R3 ready still low without request", 32'(ready), 0);
      drq = 1'b1;
      repeat (SYNC - 1) tick();
      #2;
      chk("R4 ready low before sync latency", 32'(ready), 0);
      tick();
      #2;
      chk("R4 ready high after sync latency", 32'(ready), 1);
      data = 1'b1;
      #2;
      chk("R5 ack_n low with data strobe", 32'(ack_n), 0);
      drq = 1'b0;
      tick();
      data = 1'b0;
      #2;
      chk("R5 ack_n high after data strobe", 32'(ack_n), 1);
      repeat (SYNC + 4) tick();
      chk("R6 ready stays high until next halt", 32'(ready), 1);
   endtask

   task automatic t_timeout();
      halt = 1'b1;
      tick();
      halt = 1'b0;
      repeat (10) tick();
      chk("R7 ready low while timeout pending", 32'(ready), 0);
      tmo = 1'b1;
      repeat (SYNC) tick();
      #2;
      chk("R7 ready high on expired timeout", 32'(ready), 1);
      tmo = 1'b0;
      repeat (SYNC + 2) tick();
      chk("R7 stall dropped after timeout", 32'(ready), 1);
   endtask

   task automatic t_pending();
      drq = 1'b1;
      repeat (SYNC + 1) tick();
      halt = 1'b1;
      #2;
      chk("R9 no stall with pending request", 32'(ready), 1);
      tick();
      halt = 1'b0;
      clr = 1'b1;
      #2;
      chk("R8 ack_n low with clear bit", 32'(ack_n), 0);
      drq = 1'b0;
      repeat (2) tick();
      chk("R8 ack_n held low while clear bit set", 32'(ack_n), 0);
      clr = 1'b0;
      #2;
      chk("R8 ack_n high after clear bit", 32'(ack_n), 1);
      repeat (SYNC + 1) tick();
      halt = 1'b1;
      #2;
      chk("R9 halt stalls after clearing request", 32'(ready), 0);
      tick();
      halt = 1'b0;
      tick();
      arm = 1'b0;
      #2;
      chk("R10 disarm releases at once", 32'(ready), 1);
      tick();
      arm = 1'b1;
      tick();
      #2;
      chk("R10 rearm without halt stays open", 32'(ready), 1);
   endtask

   task automatic t_transfer();
      int stalled = 0;
      int ack_bad = 0;
      int hung = 0;
      int mism = 0;
      for (int i = 0; i < NBYTES; i++) begin
         int d;
         int w;
         d = int'($urandom_range(0, 6));
         halt = 1'b1;
         #2;
         if (!ready) stalled++;
         tick();
         halt = 1'b0;
         repeat (d) tick();
         ctl_byte = pattern(i);
         drq = 1'b1;
         w = 0;
         while (!ready && w < 40) begin
            tick();
            w++;
         end
         if (!ready) hung++;
         data = 1'b1;
         #2;
         if (ack_n) ack_bad++;
         mem[i] = ack_n ? 8'h00 : ctl_byte;
         drq = 1'b0;
         tick();
         data = 1'b0;
         repeat (SYNC + 1) tick();
      end
      for (int i = 0; i < NBYTES; i++) begin
         if (mem[i] !== pattern(i)) mism++;
      end
      chk("R11 every halt stalled", 32'(stalled), 32'(NBYTES));
      chk("R11 no hung pass", 32'(hung), 0);
      chk("R5 ack on every data access", 32'(ack_bad), 0);
      chk("R11 bytes stored in order", 32'(mism), 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_disarmed();
      t_stall_release();
      t_timeout();
      t_pending();
      t_transfer();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule